// File: doc/BRIEF.md
# Command-Driven SPI Master Engine

This block is a single-channel SPI master. Software loads 32-bit words into an eight-entry transmit queue and then writes one command word. The command picks transmit, receive or full duplex, gives the length of the transfer in bits, and says whether chip select stays asserted once the transfer ends. The engine shifts the bits out on a serial clock derived from the system clock by a programmable divider. It applies the configured clock polarity, clock phase, chip-select polarity and bit order, and packs the sampled input bits into words in an eight-entry receive queue.

Each word in either queue carries its first byte in the most significant byte. A final word that holds fewer than four bytes keeps them right-aligned, so the last byte of the transfer sits in bits [7:0]. A frame longer than one command can carry is built by chaining commands with the continue flag set. A command whose operation field is zero releases a chip select that is being held. An optional capture delay moves the input sampling point one system cycle later when the divider is at its minimum, to absorb loop delay on the board.

Top module: `spi_cmd_master`

## Requirements
- R1: After reset the configuration register reads 0x034 and the divider reads 4. Both occupancy counts are 0, `busy` is low, `sclk` is low and `spi_cs` is high, which is the deasserted level for the reset polarity.
- R2: Register 1 is the divider. A value written below 4 reads back as 4. Each serial bit lasts exactly divider system cycles.
- R3: Register 2 is the command. Bits [1:0] hold the operation (1 transmit, 2 receive, 3 both). Bit 4 is continue. Bits [23:16] hold the length in bits minus one. An accepted command raises `busy` for exactly (length+1) × divider cycles.
- R4: A command written while `busy` is high has no effect. The running transfer keeps its length and the queues see no extra traffic.
- R5: When `busy` is low, `sclk` rests at configuration bit 1 (CPOL).
- R6: With configuration bit 0 (CPHA) at 0, input is sampled on the leading clock edge. With CPHA at 1, it is sampled on the trailing edge. MOSI looped back to MISO returns the sent data in all four clock modes.
- R7: The first byte on the wire comes from the most significant byte of a full word. A final partial word of n bytes sends bits [8n-1:8n-8] first and receives into the same right-aligned places.
- R8: Within each byte, bits go out MSB first by default and LSB first when configuration bit 10 is set.
- R9: Configuration bit 2 set makes chip select active low. Chip select is asserted for the whole transfer, stays asserted after a command with continue set, and is released by a command whose operation is 0.
- R10: Register 3 reports receive occupancy in bits [3:0] and transmit occupancy in bits [7:4]. Register 4 pushes a transmit word and reading register 5 pops a receive word. A push to a full queue of 8 is dropped.
- R11: With configuration bit 5 clear, or with a transmit-only command, no receive words are written. A receive-only command consumes no transmit words.
- R12: With configuration bit 11 set and the divider at 4, input is sampled one system cycle after the nominal edge.
- R13: `mosi_oe` follows configuration bit 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (pops the receive queue at register 5) |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational on `reg_addr`) |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| mosi_oe | output | 1 | Output enable for `mosi` |
| miso | input | 1 | Serial data in |
| spi_cs | output | 1 | Chip select at the configured polarity |
| busy | output | 1 | Transfer pending |

## Verification
`busy` rises at the clock edge that takes the command write, and falls at the edge that ends the trailing phase of the last bit. The bench therefore counts `busy` at falling edges and expects exactly (length+1) × divider samples, with an ignored command injected partway through the count. Queue counts and received words are read only after `busy` has been low for three cycles. That margin covers the one-cycle late capture path. Bit order is taken from `mosi` at each rising `sclk` seen at a system edge, and register reads are sampled one time unit after the address settles, before the edge that pops.

// File: rtl/spi_cmd_pkg.sv
// Shared constants for the command-driven SPI master: register indices,
// configuration bit positions and command field positions.
package spi_cmd_pkg;
    localparam logic [2:0] ADR_CFG = 3'd0;
    localparam logic [2:0] ADR_DIV = 3'd1;
    localparam logic [2:0] ADR_CMD = 3'd2;
    localparam logic [2:0] ADR_CNT = 3'd3;
    localparam logic [2:0] ADR_TXD = 3'd4;
    localparam logic [2:0] ADR_RXD = 3'd5;

    localparam int CFG_W     = 12;
    localparam int CFG_CPHA  = 0;
    localparam int CFG_CPOL  = 1;
    localparam int CFG_CSPOL = 2;
    localparam int CFG_TXEN  = 4;
    localparam int CFG_RXEN  = 5;
    localparam int CFG_LSB   = 10;
    localparam int CFG_ADJ   = 11;
    localparam logic [CFG_W-1:0] CFG_MASK  = 12'hC37;
    localparam logic [CFG_W-1:0] CFG_RESET = 12'h034;

    localparam int CMD_CONT    = 4;
    localparam int CMD_LEN_LSB = 16;
endpackage

// File: rtl/spi_word_fifo.sv
// Synchronous word queue with occupancy count.
// Assumes DEPTH is a power of two; pushes when full and pops when empty are dropped.
module spi_word_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [CW-1:0]    count
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign do_push = push && (count != CW'(DEPTH));
    assign do_pop  = pop && (count != '0);
    assign head    = mem[rd_ptr];

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/spi_sclk_timer.sv
// Divides the system clock into serial bit periods of DIV cycles.
// Flags the leading-edge cycle (DIV/2 - 1) and trailing-edge cycle (DIV - 1)
// while run is high. Assumes div >= 4 so the two events never coincide.
module spi_sclk_timer #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             lead,
    output logic             trail
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] half;

    assign half  = div >> 1;
    assign lead  = run && (cnt == half - DIV_W'(1));
    assign trail = run && (cnt == div - DIV_W'(1));

    // Phase counter, held at zero while no transfer runs.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (trail)     cnt <= '0;
        else                cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/spi_cmd_master.sv
// Command-driven single-channel SPI master.
// One command runs one transfer of up to 2**LEN_W bits, taking transmit
// words from one queue and packing sampled bits into another. Assumes
// DATA_W is a power-of-two multiple of 8 and transfer lengths are whole bytes.
module spi_cmd_master
    import spi_cmd_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int FIFO_DEPTH = 8,
    parameter int DIV_W      = 16,
    parameter int LEN_W      = 8,
    parameter int DIV_MIN    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic              reg_re,
    input  logic [2:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              sclk,
    output logic              mosi,
    output logic              mosi_oe,
    input  logic              miso,
    output logic              spi_cs,
    output logic              busy
);
    localparam int BYTES = DATA_W / 8;
    localparam int BI_W  = $clog2(BYTES);
    localparam int NB_W  = BI_W + 1;
    localparam int POS_W = BI_W + 3;
    localparam int CW    = $clog2(FIFO_DEPTH + 1);
    localparam int LEN1  = LEN_W + 1;

    // Bytes held by the next word, given the bits still to move.
    function automatic logic [NB_W-1:0] nbytes_for(input logic [LEN_W:0] nbits);
        logic [LEN_W:0] up;
        up = nbits + LEN1'(7);
        if (nbits >= LEN1'(DATA_W)) return NB_W'(BYTES);
        return NB_W'(up >> 3);
    endfunction

    logic [CFG_W-1:0]  cfg_q;
    logic [DIV_W-1:0]  div_q, div_new;
    logic              wr_cfg, wr_div, wr_cmd, tx_push, rx_pop;
    logic [1:0]        cmd_op;
    logic              cmd_cont, cmd_go, cmd_idle;
    logic [LEN_W-1:0]  cmd_len;

    logic              busy_q, cs_act_q, tx_on_q, rx_on_q, cont_q, sclk_q;
    logic [LEN_W-1:0]  bits_left_q;
    logic [BI_W-1:0]   byte_q;
    logic [2:0]        bit_q, bsel;
    logic [NB_W-1:0]   wbytes_q, slot;
    logic              lead, trail, last_bit, last_byte, word_end;
    logic [POS_W-1:0]  pos;

    logic [DATA_W-1:0] tx_head, rx_head, rx_acc_q, rx_word;
    logic [CW-1:0]     tx_cnt, rx_cnt;
    logic              tx_pop, samp, adj, rx_push;
    logic              cap_v_q, cap_end_q, cap_v, cap_end;
    logic [POS_W-1:0]  cap_pos_q, cap_pos;

    assign wr_cfg  = reg_we && (reg_addr == ADR_CFG);
    assign wr_div  = reg_we && (reg_addr == ADR_DIV);
    assign wr_cmd  = reg_we && (reg_addr == ADR_CMD);
    assign tx_push = reg_we && (reg_addr == ADR_TXD);
    assign rx_pop  = reg_re && (reg_addr == ADR_RXD);

    assign cmd_op   = reg_wdata[1:0];
    assign cmd_cont = reg_wdata[CMD_CONT];
    assign cmd_len  = reg_wdata[CMD_LEN_LSB +: LEN_W];
    assign cmd_go   = wr_cmd && !busy_q && (cmd_op != 2'd0);
    assign cmd_idle = wr_cmd && !busy_q && (cmd_op == 2'd0);
    assign div_new  = reg_wdata[DIV_W-1:0];

    // Configuration and divider registers; the divider is floored at DIV_MIN.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= CFG_RESET;
            div_q <= DIV_W'(DIV_MIN);
        end else begin
            if (wr_cfg) cfg_q <= reg_wdata[CFG_W-1:0] & CFG_MASK;
            if (wr_div) div_q <= (div_new < DIV_W'(DIV_MIN)) ? DIV_W'(DIV_MIN) : div_new;
        end
    end

    spi_sclk_timer #(.DIV_W(DIV_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy_q),
        .div   (div_q),
        .lead  (lead),
        .trail (trail)
    );

    assign last_bit  = (bits_left_q == '0);
    assign last_byte = (({1'b0, byte_q} + NB_W'(1)) == wbytes_q);
    assign word_end  = last_bit || (last_byte && (bit_q == 3'd7));
    assign slot      = wbytes_q - NB_W'(1) - {1'b0, byte_q};
    assign bsel      = cfg_q[CFG_LSB] ? bit_q : ~bit_q;
    assign pos       = {slot[BI_W-1:0], bsel};

    // Transfer sequencer: command acceptance, bit/byte/word stepping, chip select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q      <= 1'b0;
            cs_act_q    <= 1'b0;
            tx_on_q     <= 1'b0;
            rx_on_q     <= 1'b0;
            cont_q      <= 1'b0;
            sclk_q      <= 1'b0;
            bits_left_q <= '0;
            byte_q      <= '0;
            bit_q       <= '0;
            wbytes_q    <= '0;
        end else if (cmd_go) begin
            busy_q      <= 1'b1;
            cs_act_q    <= 1'b1;
            tx_on_q     <= cmd_op[0];
            rx_on_q     <= cmd_op[1] && cfg_q[CFG_RXEN];
            cont_q      <= cmd_cont;
            sclk_q      <= 1'b0;
            bits_left_q <= cmd_len;
            byte_q      <= '0;
            bit_q       <= '0;
            wbytes_q    <= nbytes_for({1'b0, cmd_len} + LEN1'(1));
        end else if (cmd_idle) begin
            cs_act_q <= 1'b0;
        end else if (busy_q) begin
            if (lead) sclk_q <= 1'b1;
            if (trail) begin
                sclk_q <= 1'b0;
                if (last_bit) begin
                    busy_q   <= 1'b0;
                    cs_act_q <= cont_q;
                end else begin
                    bits_left_q <= bits_left_q - 1'b1;
                    if (bit_q == 3'd7) begin
                        bit_q <= '0;
                        if (last_byte) begin
                            byte_q   <= '0;
                            wbytes_q <= nbytes_for({1'b0, bits_left_q});
                        end else begin
                            byte_q <= byte_q + 1'b1;
                        end
                    end else begin
                        bit_q <= bit_q + 1'b1;
                    end
                end
            end
        end
    end

    assign tx_pop  = busy_q && trail && word_end && tx_on_q;
    assign samp    = busy_q && rx_on_q && (cfg_q[CFG_CPHA] ? trail : lead);
    assign adj     = cfg_q[CFG_ADJ] && (div_q == DIV_W'(DIV_MIN));
    assign cap_v   = adj ? cap_v_q   : samp;
    assign cap_pos = adj ? cap_pos_q : pos;
    assign cap_end = adj ? cap_end_q : word_end;
    assign rx_push = cap_v && cap_end;

    // One-cycle copy of the capture request for the late sampling option.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_v_q   <= 1'b0;
            cap_pos_q <= '0;
            cap_end_q <= 1'b0;
        end else begin
            cap_v_q   <= samp;
            cap_pos_q <= pos;
            cap_end_q <= word_end;
        end
    end

    // Place the sampled bit into the word being assembled.
    always_comb begin
        rx_word          = rx_acc_q;
        rx_word[cap_pos] = miso;
    end

    // Receive word accumulator, cleared as each word is handed to the queue.
    always_ff @(posedge clk) begin
        if (!rst_n)     rx_acc_q <= '0;
        else if (cap_v) rx_acc_q <= cap_end ? '0 : rx_word;
    end

    spi_word_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (tx_push),
        .din   (reg_wdata),
        .pop   (tx_pop),
        .head  (tx_head),
        .count (tx_cnt)
    );

    spi_word_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rx_push),
        .din   (rx_word),
        .pop   (rx_pop),
        .head  (rx_head),
        .count (rx_cnt)
    );

    // Register read multiplexer.
    always_comb begin
        case (reg_addr)
            ADR_CFG: reg_rdata = DATA_W'(cfg_q);
            ADR_DIV: reg_rdata = DATA_W'(div_q);
            ADR_CNT: reg_rdata = (DATA_W'(tx_cnt) << 4) | DATA_W'(rx_cnt);
            ADR_RXD: reg_rdata = rx_head;
            default: reg_rdata = '0;
        endcase
    end

    assign mosi    = busy_q && tx_on_q && (tx_cnt != '0) && tx_head[pos];
    assign mosi_oe = cfg_q[CFG_TXEN];
    assign sclk    = sclk_q ^ cfg_q[CFG_CPOL];
    assign spi_cs  = cs_act_q ? ~cfg_q[CFG_CSPOL] : cfg_q[CFG_CSPOL];
    assign busy    = busy_q;
endmodule

// File: rtl/spi_cmd_master_chk.sv
// Property checker for spi_cmd_master, attached by bind below.
// Observes pins and sequencer state; drives nothing.
module spi_cmd_master_chk #(
    parameter int CW      = 4,
    parameter int DEPTH   = 8,
    parameter int DIV_W   = 16,
    parameter int DIV_MIN = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             sclk,
    input logic             spi_cs,
    input logic             cpol,
    input logic             cspol,
    input logic [DIV_W-1:0] div_val,
    input logic [CW-1:0]    tx_cnt,
    input logic [CW-1:0]    rx_cnt,
    input logic             trail,
    input logic             last_bit
);
    // R5
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sclk == cpol));

    // R9
    cs_during_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (spi_cs == ~cspol));

    // R10
    fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cnt <= CW'(DEPTH)) && (rx_cnt <= CW'(DEPTH)));

    // R2
    div_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_val >= DIV_W'(DIV_MIN));

    // R4
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !(trail && last_bit)) |=> busy);

    // R3
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(trail && last_bit));
endmodule

bind spi_cmd_master spi_cmd_master_chk #(
    .CW      (CW),
    .DEPTH   (FIFO_DEPTH),
    .DIV_W   (DIV_W),
    .DIV_MIN (DIV_MIN)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .sclk     (sclk),
    .spi_cs   (spi_cs),
    .cpol     (cfg_q[1]),
    .cspol    (cfg_q[2]),
    .div_val  (div_q),
    .tx_cnt   (tx_cnt),
    .rx_cnt   (rx_cnt),
    .trail    (trail),
    .last_bit (last_bit)
);

// File: tb/spi_cmd_master_tb.sv
// Self-checking bench: table of transfers walked in one loop, then directed cases.
module spi_cmd_master_tb;
    import spi_cmd_pkg::*;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [11:0] cfg;
        logic [15:0] div;
        logic [31:0] cmd;
        logic [1:0]  ntx;
        logic [31:0] tx0;
        logic [31:0] tx1;
        logic [1:0]  mmode;
        logic [1:0]  nrx;
        logic [31:0] rx0;
        logic [31:0] rx1;
    } vec_t;

    // mmode: 0 loopback, 1 constant one, 2 loopback delayed two cycles
    localparam vec_t VECS [8] = '{
        '{12'h034, 16'd4, 32'h001F_0003, 2'd1, 32'hA5C3_0F81, 32'h0, 2'd0, 2'd1, 32'hA5C3_0F81, 32'h0},
        '{12'h037, 16'd6, 32'h002F_0003, 2'd2, 32'h1122_3344, 32'h0000_5566, 2'd0, 2'd2, 32'h1122_3344, 32'h0000_5566},
        '{12'h434, 16'd8, 32'h000F_0003, 2'd1, 32'h0000_BEEF, 32'h0, 2'd0, 2'd1, 32'h0000_BEEF, 32'h0},
        '{12'h034, 16'd5, 32'h0017_0002, 2'd0, 32'h0, 32'h0, 2'd1, 2'd1, 32'h00FF_FFFF, 32'h0},
        '{12'h034, 16'd4, 32'h0007_0001, 2'd1, 32'h0000_005A, 32'h0, 2'd0, 2'd0, 32'h0, 32'h0},
        '{12'h014, 16'd4, 32'h000F_0003, 2'd1, 32'h0000_1234, 32'h0, 2'd0, 2'd0, 32'h0, 32'h0},
        '{12'h834, 16'd4, 32'h001F_0003, 2'd1, 32'hDEAD_BEEF, 32'h0, 2'd2, 2'd1, 32'hDEAD_BEEF, 32'h0},
        '{12'h035, 16'd4, 32'h001F_0003, 2'd1, 32'h0F0F_3C3C, 32'h0, 2'd0, 2'd1, 32'h0F0F_3C3C, 32'h0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0, reg_re = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        sclk, mosi, mosi_oe, miso, spi_cs, busy;
    logic [1:0]  mmode = 2'd0;
    logic        dly1 = 1'b0, dly2 = 1'b0, prev_sclk = 1'b0;
    logic [31:0] rec = 32'h0;
    int          total = 0, bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_cmd_master u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sclk(sclk), .mosi(mosi), .mosi_oe(mosi_oe), .miso(miso),
        .spi_cs(spi_cs), .busy(busy)
    );

    // Peripheral model: loopback, constant, or delayed loopback.
    always_ff @(posedge clk) begin
        dly1 <= mosi;
        dly2 <= dly1;
    end
    assign miso = (mmode == 2'd1) ? 1'b1 : (mmode == 2'd2) ? dly2 : mosi;

    // Record MOSI at every rising serial clock (used with CPOL 0).
    always_ff @(posedge clk) begin
        prev_sclk <= sclk;
        if (sclk && !prev_sclk) rec <= {rec[30:0], mosi};
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic pop, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_re = pop;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_re = 1'b0;
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (busy && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        repeat (3) @(negedge clk);
    endtask

    // Counts busy samples from the command write; injects a command at sample 20.
    task automatic busy_len(input logic [31:0] cmd, output int n);
        n = 0;
        wr(ADR_CMD, cmd);
        while (busy && n < 5000) begin
            n++;
            if (n == 20) begin
                reg_addr = ADR_CMD; reg_wdata = 32'h0007_0003; reg_we = 1'b1;
            end else begin
                reg_we = 1'b0;
            end
            @(negedge clk);
        end
        reg_we = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        total++; bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 cs", 32'(spi_cs), 32'h1);
        check("R1 sclk", 32'(sclk), 32'h0);
        check("R1 busy", 32'(busy), 32'h0);
        rd(ADR_CFG, 1'b0, d); check("R1 cfg", d, 32'h034);
        rd(ADR_DIV, 1'b0, d); check("R1 div", d, 32'd4);
        rd(ADR_CNT, 1'b0, d); check("R1 counts", d, 32'h0);

        // Table of transfers (R3 R6 R7 R8 R11 R12)
        for (int i = 0; i < 8; i++) begin
            mmode = VECS[i].mmode;
            wr(ADR_CFG, 32'(VECS[i].cfg));
            wr(ADR_DIV, 32'(VECS[i].div));
            if (VECS[i].ntx > 0) wr(ADR_TXD, VECS[i].tx0);
            if (VECS[i].ntx > 1) wr(ADR_TXD, VECS[i].tx1);
            wr(ADR_CMD, VECS[i].cmd);
            wait_idle();
            rd(ADR_CNT, 1'b0, d);
            check($sformatf("R11 vec%0d rx count", i), 32'(d[3:0]), 32'(VECS[i].nrx));
            check($sformatf("R11 vec%0d tx count", i), 32'(d[7:4]), 32'h0);
            if (VECS[i].nrx > 0) begin
                rd(ADR_RXD, 1'b1, d);
                check($sformatf("R6 R7 vec%0d word0", i), d, VECS[i].rx0);
            end
            if (VECS[i].nrx > 1) begin
                rd(ADR_RXD, 1'b1, d);
                check($sformatf("R7 vec%0d word1", i), d, VECS[i].rx1);
            end
        end

        // R5 idle level follows CPOL
        mmode = 2'd0;
        wr(ADR_CFG, 32'h036);
        check("R5 idle high", 32'(sclk), 32'h1);
        wr(ADR_CFG, 32'h034);
        check("R5 idle low", 32'(sclk), 32'h0);

        // R13 output enable
        check("R13 oe on", 32'(mosi_oe), 32'h1);
        wr(ADR_CFG, 32'h024);
        check("R13 oe off", 32'(mosi_oe), 32'h0);
        wr(ADR_CFG, 32'h034);

        // R2 divider floor
        wr(ADR_DIV, 32'd3);
        rd(ADR_DIV, 1'b0, d); check("R2 clamp", d, 32'd4);
        wr(ADR_DIV, 32'd9);
        rd(ADR_DIV, 1'b0, d); check("R2 keep", d, 32'd9);

        // R3 R4 duration with an ignored command mid-transfer
        wr(ADR_DIV, 32'd4);
        wr(ADR_TXD, 32'hCAFE_F00D);
        busy_len(32'h001F_0003, n);
        check("R4 R3 busy cycles div4", 32'(n), 32'd128);
        rd(ADR_CNT, 1'b0, d); check("R4 rx count", d, 32'h1);
        rd(ADR_RXD, 1'b1, d); check("R4 data", d, 32'hCAFE_F00D);
        wr(ADR_DIV, 32'd6);
        wr(ADR_TXD, 32'h0000_0011);
        busy_len(32'h0007_0001, n);
        check("R2 busy cycles div6", 32'(n), 32'd48);

        // R8 R7 bit order on the wire
        wr(ADR_DIV, 32'd4);
        wr(ADR_TXD, 32'h0000_0096);
        wr(ADR_CMD, 32'h0007_0001); wait_idle();
        check("R8 msb first", 32'(rec[7:0]), 32'h96);
        wr(ADR_CFG, 32'h434);
        wr(ADR_TXD, 32'h0000_0096);
        wr(ADR_CMD, 32'h0007_0001); wait_idle();
        check("R8 lsb first", 32'(rec[7:0]), 32'h69);
        wr(ADR_CFG, 32'h034);
        wr(ADR_TXD, 32'h0000_A1B2);
        wr(ADR_CMD, 32'h000F_0001); wait_idle();
        check("R7 partial word order", 32'(rec[15:0]), 32'hA1B2);

        // R9 chip select hold and release
        wr(ADR_TXD, 32'h0000_00AB);
        wr(ADR_CMD, 32'h0007_0011); wait_idle();
        check("R9 held", 32'(spi_cs), 32'h0);
        wr(ADR_CMD, 32'h0000_0000);
        check("R9 released", 32'(spi_cs), 32'h1);

        // R10 full queue and drain
        for (int k = 0; k < 9; k++) wr(ADR_TXD, 32'(k));
        rd(ADR_CNT, 1'b0, d); check("R10 tx full", d, 32'h80);
        wr(ADR_CMD, 32'h00FF_0001); wait_idle();
        rd(ADR_CNT, 1'b0, d); check("R10 drained", d, 32'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule